// File: doc/BRIEF.md
# Accelerator Command and Configuration Register Slave

This block is the software-facing control point of a matrix-multiply accelerator. A processor reaches it through a simple memory-mapped register port with separate write and read channels. The port has eight 32-bit word slots at byte offsets 0x00 through 0x1C. The block turns writes to a command slot into single-cycle launch pulses toward the data-moving engines and the compute array. It keeps the computation settings and three memory base addresses in registers and drives them continuously as outputs. It raises a level interrupt when a launched operation reports completion.

Only one operation is in flight at a time. A command that arrives while an operation is outstanding is dropped. The interrupt stays asserted until software acknowledges it, either by writing the command slot or by reading it. A separate slot produces a buffer-swap pulse that is independent of the launch, busy and interrupt logic.

Top module: `accel_csr`

## Requirements
- R1: After reset all stored registers read as zero, every launch and swap pulse is low, `irq_o` is low, `rd_valid_o` is low and no operation is outstanding.
- R2: The settings word at offset 0x08 is written byte by byte under `wr_strb_i`, where bit b of the strobe enables byte b. It is decoded onto the outputs as follows: bits 7:0 give `cfg_rows_m1_o`, bits 19:16 give `cfg_bias_shl_o`, bits 23:20 give `cfg_acc_shr_o` and bits 31:24 give `cfg_acc_mul_o`. The word reads back unchanged.
- R3: The base address registers are the output-store base at offset 0x14, the weight-load base at 0x0C and the input-load base at 0x10. Each is written under byte strobes, reads back unchanged and drives its own output.
- R4: A write of value 1, 2, 3 or 4 to offset 0x04 while idle raises, for exactly the one cycle after the write edge, the pulse for that value: 1 `go_wload_o`, 2 `go_iload_o`, 3 `go_ostore_o` and 4 `go_run_o`. At most one of these pulses is high at once.
- R5: A write to offset 0x04 with any other full 32-bit value raises no pulse and leaves the block idle.
- R6: After a launch the block is busy until the done input bit for the launched code is seen high (`done_i` bit code-1). While busy, command writes raise no pulse, and done bits of other codes have no effect.
- R7: `irq_o` rises in the cycle after the done bit of the outstanding operation is sampled, and it stays high until it is acknowledged.
- R8: Any write to offset 0x04 or any read of offset 0x04 clears `irq_o`. If a completion is sampled in the same cycle as such an acknowledge, `irq_o` ends high.
- R9: Any write to offset 0x18 raises `go_flip_o` for one cycle, even while busy. It neither sets nor clears `irq_o`.
- R10: A read returns data with `rd_valid_o` high in the cycle after `rd_en_i` is sampled. Offsets 0x00, 0x04, 0x18 and 0x1C always read as zero.
- R11: `cfg_relu_en_o` is high whenever any bit of the settings word bits 15:8 is set.
- R12: A write whose address bits 1:0 are not zero changes nothing, and a read at such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write request, one cycle per write |
| wr_addr_i | input | 5 | Write byte address |
| wr_data_i | input | 32 | Write data |
| wr_strb_i | input | 4 | Byte enables for write |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 5 | Read byte address |
| rd_data_o | output | 32 | Read data, registered |
| rd_valid_o | output | 1 | Read data valid |
| done_i | input | 4 | Completion strobes, bit code-1 |
| go_wload_o | output | 1 | Weight-load launch pulse |
| go_iload_o | output | 1 | Input-load launch pulse |
| go_ostore_o | output | 1 | Output-store launch pulse |
| go_run_o | output | 1 | Compute launch pulse |
| go_flip_o | output | 1 | Buffer-swap pulse |
| irq_o | output | 1 | Completion interrupt, level |
| cfg_rows_m1_o | output | 8 | Row count minus one |
| cfg_relu_en_o | output | 1 | Rectifier enable |
| cfg_bias_shl_o | output | 4 | Bias left shift |
| cfg_acc_shr_o | output | 4 | Accumulator right shift |
| cfg_acc_mul_o | output | 8 | Accumulator scale factor |
| wbase_o | output | 32 | Weight-load base address |
| ibase_o | output | 32 | Input-load base address |
| obase_o | output | 32 | Output-store base address |

## Verification
Two pairs of events can fall on the same edge and are tested on purpose. The first pair is a completion strobe and an interrupt acknowledge. The second pair is a completion strobe and a new command that would be legal one cycle later. The bench drives both inputs in the same cycle. In the first case it expects the interrupt to end high. In the second it expects no launch pulse, because the block is still busy on that edge, and then expects a repeat of the same command to launch and to clear the interrupt.

// File: rtl/accel_csr_pkg.sv
package accel_csr_pkg;

  localparam int CSR_ADDR_W = 5;
  localparam int CSR_DATA_W = 32;
  localparam int CSR_NUM_OPS = 4;
  localparam int CSR_SLOT_LSB = 2;
  localparam int CSR_SLOT_W = 3;
  localparam int CSR_STORE_WORDS = 4;

  typedef enum logic [CSR_SLOT_W-1:0] {
    SLOT_PAD_LO = 3'd0,
    SLOT_CMD    = 3'd1,
    SLOT_CFG    = 3'd2,
    SLOT_WBASE  = 3'd3,
    SLOT_IBASE  = 3'd4,
    SLOT_OBASE  = 3'd5,
    SLOT_FLIP   = 3'd6,
    SLOT_PAD_HI = 3'd7
  } slot_e;

  // Settings word layout, most significant field first.
  typedef struct packed {
    logic [7:0] acc_mul;
    logic [3:0] acc_shr;
    logic [3:0] bias_shl;
    logic [7:0] relu;
    logic [7:0] rows_m1;
  } cfg_t;

endpackage

// File: rtl/accel_csr_regfile.sv
module accel_csr_regfile
  import accel_csr_pkg::*;
#(
  parameter int DATA_W = CSR_DATA_W,
  parameter int WORDS  = CSR_STORE_WORDS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_hit,
  input  logic [CSR_SLOT_W-1:0]   wr_slot,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [DATA_W/8-1:0]     wr_strb,
  output logic [WORDS-1:0][DATA_W-1:0] words
);

  localparam int NBYTES = DATA_W / 8;
  localparam int FIRST  = int'(SLOT_CFG);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic sel;
    assign sel = wr_hit && (wr_slot == CSR_SLOT_W'(FIRST + w));
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      logic       byte_en;
      logic [7:0] byte_d;
      logic [7:0] byte_q;

      always_comb begin
        byte_en = sel && wr_strb[b];
        byte_d  = wr_data[b*8 +: 8];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          byte_q <= 8'h00;
        end else if (byte_en) begin
          byte_q <= byte_d;
        end
      end

      assign words[w][b*8 +: 8] = byte_q;
    end
  end

  AST_STORE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(words)); // R2

endmodule

// File: rtl/accel_csr_cmd.sv
module accel_csr_cmd
  import accel_csr_pkg::*;
#(
  parameter int DATA_W  = CSR_DATA_W,
  parameter int NUM_OPS = CSR_NUM_OPS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [DATA_W-1:0]  cmd_data,
  input  logic               cmd_rd,
  input  logic               flip_wr,
  input  logic [NUM_OPS-1:0] done_i,
  output logic [NUM_OPS-1:0] launch_o,
  output logic               flip_o,
  output logic               irq_o
);

  logic [NUM_OPS-1:0] active_q, active_d;
  logic [NUM_OPS-1:0] launch_q, launch_d;
  logic               irq_q, irq_d;
  logic               flip_q, flip_d;
  logic               busy;
  logic               code_ok;
  logic               accept;
  logic               done_hit;
  logic               ack;

  always_comb begin
    busy     = |active_q;
    code_ok  = (cmd_data != '0) && (cmd_data <= DATA_W'(NUM_OPS));
    accept   = cmd_wr && code_ok && !busy;
    done_hit = |(done_i & active_q);
    ack      = cmd_wr || cmd_rd;
  end

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_decode
    assign launch_d[i] = accept && (cmd_data == DATA_W'(i + 1));
  end

  always_comb begin
    active_d = active_q;
    if (done_hit) begin
      active_d = '0;
    end else if (accept) begin
      active_d = launch_d;
    end
    // completion wins over acknowledge
    irq_d = irq_q;
    if (done_hit) begin
      irq_d = 1'b1;
    end else if (ack) begin
      irq_d = 1'b0;
    end
    flip_d = flip_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      launch_q <= '0;
      irq_q    <= 1'b0;
      flip_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      launch_q <= launch_d;
      irq_q    <= irq_d;
      flip_q   <= flip_d;
    end
  end

  assign launch_o = launch_q;
  assign flip_o   = flip_q;
  assign irq_o    = irq_q;

  AST_LAUNCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(launch_q)); // R4
  AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|launch_q) |=> !(|launch_q)); // R4
  AST_LAUNCH_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (|launch_q) |-> (launch_q == active_q)); // R6
  AST_BUSY_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|active_q) |-> !irq_q); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !cmd_wr && !cmd_rd) |=> irq_q); // R7
  AST_IRQ_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(|active_q)); // R7
  AST_FLIP_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_wr && !cmd_wr && !cmd_rd && irq_q) |=> irq_q); // R9

endmodule

// File: rtl/accel_csr_rdmux.sv
module accel_csr_rdmux
  import accel_csr_pkg::*;
#(
  parameter int DATA_W = CSR_DATA_W,
  parameter int WORDS  = CSR_STORE_WORDS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic                         rd_aligned,
  input  logic [CSR_SLOT_W-1:0]        rd_slot,
  input  logic [WORDS-1:0][DATA_W-1:0] words,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         rd_valid
);

  logic [DATA_W-1:0] data_d, data_q;
  logic              valid_q;

  always_comb begin
    data_d = '0;
    if (rd_aligned) begin
      unique case (slot_e'(rd_slot))
        SLOT_CFG:   data_d = words[0];
        SLOT_WBASE: data_d = words[1];
        SLOT_IBASE: data_d = words[2];
        SLOT_OBASE: data_d = words[3];
        default:    data_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (rd_en) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;

  AST_RD_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en)); // R10
  AST_RD_WO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_slot == 3'd0 || rd_slot == 3'd1 || rd_slot == 3'd6 || rd_slot == 3'd7))
      |=> (rd_data == '0)); // R10
  AST_RD_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_aligned) |=> (rd_data == '0)); // R12

endmodule

// File: rtl/accel_csr.sv
module accel_csr
  import accel_csr_pkg::*;
#(
  parameter int ADDR_W  = CSR_ADDR_W,
  parameter int DATA_W  = CSR_DATA_W,
  parameter int NUM_OPS = CSR_NUM_OPS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [DATA_W/8-1:0] wr_strb_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               rd_valid_o,
  input  logic [NUM_OPS-1:0] done_i,
  output logic               go_wload_o,
  output logic               go_iload_o,
  output logic               go_ostore_o,
  output logic               go_run_o,
  output logic               go_flip_o,
  output logic               irq_o,
  output logic [7:0]         cfg_rows_m1_o,
  output logic               cfg_relu_en_o,
  output logic [3:0]         cfg_bias_shl_o,
  output logic [3:0]         cfg_acc_shr_o,
  output logic [7:0]         cfg_acc_mul_o,
  output logic [DATA_W-1:0]  wbase_o,
  output logic [DATA_W-1:0]  ibase_o,
  output logic [DATA_W-1:0]  obase_o
);

  localparam int WORDS = CSR_STORE_WORDS;

  logic [CSR_SLOT_W-1:0]        wr_slot, rd_slot;
  logic                         wr_aligned, rd_aligned;
  logic                         wr_hit;
  logic                         cmd_wr, cmd_rd, flip_wr;
  logic [WORDS-1:0][DATA_W-1:0] words;
  logic [NUM_OPS-1:0]           launch;
  cfg_t                         cfg;

  always_comb begin
    wr_slot    = wr_addr_i[CSR_SLOT_LSB +: CSR_SLOT_W];
    rd_slot    = rd_addr_i[CSR_SLOT_LSB +: CSR_SLOT_W];
    wr_aligned = (wr_addr_i[CSR_SLOT_LSB-1:0] == '0);
    rd_aligned = (rd_addr_i[CSR_SLOT_LSB-1:0] == '0);
    wr_hit     = wr_en_i && wr_aligned;
    cmd_wr     = wr_hit && (slot_e'(wr_slot) == SLOT_CMD);
    flip_wr    = wr_hit && (slot_e'(wr_slot) == SLOT_FLIP);
    cmd_rd     = rd_en_i && rd_aligned && (slot_e'(rd_slot) == SLOT_CMD);
  end

  accel_csr_regfile #(
    .DATA_W (DATA_W),
    .WORDS  (WORDS)
  ) regfile_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (wr_hit),
    .wr_slot (wr_slot),
    .wr_data (wr_data_i),
    .wr_strb (wr_strb_i),
    .words   (words)
  );

  accel_csr_cmd #(
    .DATA_W  (DATA_W),
    .NUM_OPS (NUM_OPS)
  ) cmd_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .cmd_data (wr_data_i),
    .cmd_rd   (cmd_rd),
    .flip_wr  (flip_wr),
    .done_i   (done_i),
    .launch_o (launch),
    .flip_o   (go_flip_o),
    .irq_o    (irq_o)
  );

  accel_csr_rdmux #(
    .DATA_W (DATA_W),
    .WORDS  (WORDS)
  ) rdmux_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en_i),
    .rd_aligned (rd_aligned),
    .rd_slot    (rd_slot),
    .words      (words),
    .rd_data    (rd_data_o),
    .rd_valid   (rd_valid_o)
  );

  always_comb begin
    cfg            = cfg_t'(words[0]);
    cfg_rows_m1_o  = cfg.rows_m1;
    cfg_relu_en_o  = |cfg.relu;
    cfg_bias_shl_o = cfg.bias_shl;
    cfg_acc_shr_o  = cfg.acc_shr;
    cfg_acc_mul_o  = cfg.acc_mul;
    wbase_o        = words[1];
    ibase_o        = words[2];
    obase_o        = words[3];
    go_wload_o     = launch[0];
    go_iload_o     = launch[1];
    go_ostore_o    = launch[2];
    go_run_o       = launch[3];
  end

  AST_MISALIGNED_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_aligned && !rd_en_i && (done_i == '0)) |=> ($stable(irq_o) && !go_flip_o)); // R12

endmodule

// File: tb/accel_csr_tb.sv
`timescale 1ns/1ps
module accel_csr_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_strb;
  logic        rd_en;
  logic [4:0]  rd_addr;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [3:0]  done;
  logic        go_wload, go_iload, go_ostore, go_run, go_flip, irq;
  logic [7:0]  rows_m1, acc_mul;
  logic        relu_en;
  logic [3:0]  bias_shl, acc_shr;
  logic [31:0] wbase, ibase, obase;

  int n_chk = 0;
  int n_err = 0;

  accel_csr dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en_i        (wr_en),
    .wr_addr_i      (wr_addr),
    .wr_data_i      (wr_data),
    .wr_strb_i      (wr_strb),
    .rd_en_i        (rd_en),
    .rd_addr_i      (rd_addr),
    .rd_data_o      (rd_data),
    .rd_valid_o     (rd_valid),
    .done_i         (done),
    .go_wload_o     (go_wload),
    .go_iload_o     (go_iload),
    .go_ostore_o    (go_ostore),
    .go_run_o       (go_run),
    .go_flip_o      (go_flip),
    .irq_o          (irq),
    .cfg_rows_m1_o  (rows_m1),
    .cfg_relu_en_o  (relu_en),
    .cfg_bias_shl_o (bias_shl),
    .cfg_acc_shr_o  (acc_shr),
    .cfg_acc_mul_o  (acc_mul),
    .wbase_o        (wbase),
    .ibase_o        (ibase),
    .obase_o        (obase)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] gos();
    return {go_run, go_ostore, go_iload, go_wload};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] s);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_strb = s;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_op(input int code);
    @(negedge clk);
    done = 4'b0001 << (code - 1);
    @(negedge clk);
    done = 4'b0000;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [31:0] exp_cfg;
    logic [31:0] exp_base [3];
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_strb = '0;
    rd_en = 1'b0; rd_addr = '0; done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pulses", {27'd0, go_flip, gos()}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R1 cfg", {acc_mul, acc_shr, bias_shl, 7'd0, relu_en, rows_m1}, 32'd0);
    chk("R1 bases", wbase | ibase | obase, 32'd0);
    rd(5'h08);
    chk("R1 cfg readback", rd_data, 32'd0);

    // R2 / R11 settings word, all strobe patterns
    exp_cfg = '0;
    for (int s = 0; s < 16; s++) begin
      logic [31:0] d;
      d = {8'(s*37+5), 8'(s*11+1), 8'(s*53), 8'(s*29+7)};
      wr(5'h08, d, 4'(s));
      exp_cfg = merge(exp_cfg, d, 4'(s));
      chk("R2 rows_m1", {24'd0, rows_m1}, {24'd0, exp_cfg[7:0]});
      chk("R2 shifts", {24'd0, acc_shr, bias_shl}, {24'd0, exp_cfg[23:20], exp_cfg[19:16]});
      chk("R2 acc_mul", {24'd0, acc_mul}, {24'd0, exp_cfg[31:24]});
      chk("R11 relu_en", {31'd0, relu_en}, {31'd0, |exp_cfg[15:8]});
      rd(5'h08);
      chk("R2 readback", rd_data, exp_cfg);
      chk("R10 rd_valid", {31'd0, rd_valid}, 32'd1);
    end
    // R11 single relu bit cases
    for (int b = 8; b < 16; b++) begin
      wr(5'h08, 32'd1 << b, 4'b0010);
      chk("R11 relu single bit", {31'd0, relu_en}, 32'd1);
    end
    wr(5'h08, 32'd0, 4'b0010);
    exp_cfg[15:8] = 8'd0;
    chk("R11 relu clear", {31'd0, relu_en}, 32'd0);

    // R3 base addresses, all strobe patterns
    for (int k = 0; k < 3; k++) exp_base[k] = '0;
    for (int k = 0; k < 3; k++) begin
      for (int s = 0; s < 16; s++) begin
        logic [31:0] d;
        logic [31:0] port;
        d = 32'h9E3779B9 * (k*16 + s + 1);
        wr(5'(12 + 4*k), d, 4'(s));
        exp_base[k] = merge(exp_base[k], d, 4'(s));
        port = (k == 0) ? wbase : (k == 1) ? ibase : obase;
        chk("R3 base output", port, exp_base[k]);
        rd(5'(12 + 4*k));
        chk("R3 base readback", rd_data, exp_base[k]);
      end
    end

    // R12 misaligned access
    for (int off = 1; off < 4; off++) begin
      wr(5'(8 + off), 32'hFFFF_FFFF, 4'hF);
      chk("R12 misaligned write", {acc_mul, acc_shr, bias_shl, exp_cfg[15:8], rows_m1}, exp_cfg);
      rd(5'(12 + off));
      chk("R12 misaligned read", rd_data, 32'd0);
    end
    wr(5'h05, 32'd1, 4'hF);
    chk("R12 misaligned cmd", {28'd0, gos()}, 32'd0);

    // R10 write-only and unused slots read zero
    for (int a = 0; a < 32; a += 4) begin
      if (a == 0 || a == 4 || a == 24 || a == 28) begin
        rd(5'(a));
        chk("R10 zero slot", rd_data, 32'd0);
      end
    end

    // R4..R8 command sweep
    for (int v = 0; v < 10; v++) begin
      logic [31:0] val;
      val = (v == 9) ? 32'h0000_0101 : 32'(v);
      wr(5'h04, val, 4'hF);
      if (val >= 1 && val <= 4) begin
        chk("R4 launch pulse", {28'd0, gos()}, {28'd0, 4'b0001 << (val - 1)});
        @(negedge clk);
        chk("R4 pulse one cycle", {28'd0, gos()}, 32'd0);
        wr(5'h04, 32'(val % 4 + 1), 4'hF);
        chk("R6 refused while busy", {28'd0, gos()}, 32'd0);
        finish_op(int'(val % 4 + 1));
        chk("R6 foreign done ignored", {31'd0, irq}, 32'd0);
        finish_op(int'(val));
        chk("R7 irq set", {31'd0, irq}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R7 irq holds", {31'd0, irq}, 32'd1);
        if (v % 2 == 0) begin
          wr(5'h04, 32'd0, 4'hF);
          chk("R8 irq cleared by write", {31'd0, irq}, 32'd0);
        end else begin
          rd(5'h04);
          chk("R8 irq cleared by read", {31'd0, irq}, 32'd0);
          chk("R10 cmd reads zero", rd_data, 32'd0);
        end
      end else begin
        chk("R5 invalid code no pulse", {28'd0, gos()}, 32'd0);
        wr(5'h04, 32'd2, 4'hF);
        chk("R5 idle after invalid", {28'd0, gos()}, 32'd2);
        finish_op(2);
        rd(5'h04);
        chk("R5 cleanup irq", {31'd0, irq}, 32'd0);
      end
    end

    // R9 flip while busy, no irq effect
    wr(5'h04, 32'd4, 4'hF);
    chk("R4 run pulse", {28'd0, gos()}, 32'd8);
    wr(5'h18, 32'd0, 4'h0);
    chk("R9 flip while busy", {31'd0, go_flip}, 32'd1);
    chk("R9 flip no irq", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R9 flip one cycle", {31'd0, go_flip}, 32'd0);
    finish_op(4);
    chk("R7 irq after run", {31'd0, irq}, 32'd1);
    wr(5'h18, 32'hDEAD_BEEF, 4'hF);
    chk("R9 flip keeps irq", {31'd0, irq}, 32'd1);
    chk("R9 flip pulse", {31'd0, go_flip}, 32'd1);

    // R8 completion and acknowledge on the same edge
    wr(5'h04, 32'd2, 4'hF);
    chk("R8 ack by new launch", {31'd0, irq}, 32'd0);
    @(negedge clk);
    done = 4'b0010; wr_en = 1'b1; wr_addr = 5'h04; wr_data = 32'd0; wr_strb = 4'hF;
    @(negedge clk);
    done = '0; wr_en = 1'b0;
    chk("R8 set wins over clear", {31'd0, irq}, 32'd1);

    // R6 completion and new command on the same edge
    wr(5'h04, 32'd3, 4'hF);
    chk("R4 ostore pulse", {28'd0, gos()}, 32'd4);
    @(negedge clk);
    done = 4'b0100; wr_en = 1'b1; wr_addr = 5'h04; wr_data = 32'd1; wr_strb = 4'hF;
    @(negedge clk);
    done = '0; wr_en = 1'b0;
    chk("R6 command refused at done edge", {28'd0, gos()}, 32'd0);
    chk("R7 irq at done edge", {31'd0, irq}, 32'd1);
    wr(5'h04, 32'd1, 4'hF);
    chk("R4 relaunch after done", {28'd0, gos()}, 32'd1);
    chk("R8 relaunch clears irq", {31'd0, irq}, 32'd0);
    finish_op(1);
    rd(5'h04);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule